// File: doc/BRIEF.md
# Asynchronous DRAM Sequencer with Periodic Refresh

This block drives a single bank of FPM/EDO-style asynchronous DRAM from a synchronous host port. A host hands over one 64-bit read or write at a time with a valid/ready handshake. The block splits the word address into a row half and a column half, which share one address bus. It then drives the active-low row strobe, column strobe and write-enable lines in the order the operation needs. Read data is captured after a CAS latency given in clock cycles, and it comes back on a one-cycle response pulse.

An interval timer requests a refresh at a fixed rate. A mode input picks one of two refresh styles. In the first, the column strobe falls ahead of the row strobe and no address is needed. In the second, only the row strobe is pulsed, on a row taken from an internal counter that wraps. A refresh that is due wins over a host request at the idle point, but it never cuts into an access already under way. A host request that arrives during a refresh waits with ready low. Every sequence ends with a precharge period in which all strobes are high.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, RAS, CAS and WE are high, the data driver is off, rsp_valid is low and req_ready is high.
- R2: A write accepted at a clock edge drives RAS low with the row (req_addr upper ROW_W bits) on mem_addr for T_RCD cycles. For the next T_CAS cycles it drives CAS and WE low together, with the column (req_addr lower COL_W bits) on mem_addr and the write word on mem_dq_out with mem_dq_oe high.
- R3: A read follows the same row-then-column order, with WE high throughout. CAS stays low for T_CL cycles. At the edge that ends the T_CL-th CAS-low cycle, mem_dq_in is captured, and rsp_valid is high with that word for the one cycle that follows.
- R4: After each access or refresh, RAS and CAS stay high for T_PRE cycles with req_ready low before any new strobe falls.
- R5: With refresh_mode = 0, a refresh drives CAS low for T_CSR cycles before RAS falls, then holds both low for T_RAS cycles.
- R6: With refresh_mode = 1, a refresh drives only RAS low for T_RAS cycles, with CAS high and the refresh row on mem_addr.
- R7: A request presented while a refresh runs sees req_ready low until that refresh and its precharge end. The request is then accepted and completes correctly.
- R8: A refresh falling due during an access does not disturb it: every access keeps the fixed strobe timing of R2/R3 across refresh ticks.
- R9: The refresh row starts at 0 after reset, steps by one after each RAS-only refresh and wraps from ROWS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DW | Write word |
| rsp_valid | output | 1 | Read word available, one cycle |
| rsp_rdata | output | DW | Read word |
| refresh_mode | input | 1 | 0 = CAS-before-RAS, 1 = RAS-only |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data driven to DRAM |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DW | Data returned by DRAM |

## Verification
All timing is counted from the clock edge at which a request is accepted. The row phase spans the next T_RCD cycles and the column phase the next T_CAS or T_CL cycles. The read response then appears in the single cycle after the last CAS-low cycle, and T_PRE precharge cycles follow. The bench samples every port on the falling clock edge. It counts those falling edges from the acceptance edge and compares each phase against the cycle index where the requirement places it. Refresh timing is read the same way: the bench counts cycles of ready low from the first CAS-low cycle of a refresh.

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DW           = 64,
  parameter int ROWS         = 1 << ROW_W,
  parameter int REF_INTERVAL = 390,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CL         = 3,
  parameter int T_CSR        = 1,
  parameter int T_RAS        = 3,
  parameter int T_PRE        = 2,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  input  logic                   refresh_mode,
  output logic [AW-1:0]          mem_addr,
  output logic                   mem_ras_n,
  output logic                   mem_cas_n,
  output logic                   mem_we_n,
  output logic [DW-1:0]          mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DW-1:0]          mem_dq_in
);
  localparam int CNT_W = 8;
  localparam int RC_W  = $clog2(REF_INTERVAL) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_COL, S_PRE, S_CBR_CAS, S_CBR_RAS, S_ROR} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0]  ref_cnt;
  logic             ref_pend;
  logic [ROW_W-1:0] ref_row, row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DW-1:0]    wdata_q;

  wire ref_tick  = ref_cnt == RC_W'(REF_INTERVAL - 1);
  wire ref_start = st == S_IDLE && ref_pend;
  wire col_last  = cnt == (wr_q ? CNT_W'(T_CAS - 1) : CNT_W'(T_CL - 1));

  assign req_ready  = st == S_IDLE && !ref_pend;
  assign mem_ras_n  = !(st == S_ACT || st == S_COL || st == S_CBR_RAS || st == S_ROR);
  assign mem_cas_n  = !(st == S_COL || st == S_CBR_CAS || st == S_CBR_RAS);
  assign mem_dq_oe  = st == S_COL && wr_q;
  assign mem_we_n   = !mem_dq_oe;
  assign mem_dq_out = wdata_q;

  always_comb begin
    case (st)
      S_ACT:   mem_addr = AW'(row_q);
      S_COL:   mem_addr = AW'(col_q);
      S_ROR:   mem_addr = AW'(ref_row);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt <= ref_tick ? '0 : ref_cnt + 1'b1;
      if (ref_start) ref_pend <= 1'b0;
      if (ref_tick)  ref_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ref_row   <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      cnt       <= cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pend) begin
            st <= refresh_mode ? S_ROR : S_CBR_CAS;
          end else if (req_valid) begin
            st      <= S_ACT;
            wr_q    <= req_write;
            row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
          end
        end
        S_ACT: if (cnt == CNT_W'(T_RCD - 1)) begin
          st  <= S_COL;
          cnt <= '0;
        end
        S_COL: if (col_last) begin
          st  <= S_PRE;
          cnt <= '0;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_in;
          end
        end
        S_CBR_CAS: if (cnt == CNT_W'(T_CSR - 1)) begin
          st  <= S_CBR_RAS;
          cnt <= '0;
        end
        S_CBR_RAS: if (cnt == CNT_W'(T_RAS - 1)) begin
          st  <= S_PRE;
          cnt <= '0;
        end
        S_ROR: if (cnt == CNT_W'(T_RAS - 1)) begin
          st      <= S_PRE;
          cnt     <= '0;
          ref_row <= (ref_row == ROW_W'(ROWS - 1)) ? '0 : ref_row + 1'b1;
        end
        S_PRE: if (cnt == CNT_W'(T_PRE - 1)) begin
          st  <= S_IDLE;
          cnt <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_seq_ctrl_chk.sv
module dram_seq_ctrl_chk #(
  parameter int T_PRE = 2,
  parameter int DW    = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [DW-1:0] mem_dq_out
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= 8'(T_PRE);
    else if (mem_ras_n && mem_cas_n) hi_cnt <= (hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  a_r2_we_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cas_n && !mem_ras_n && mem_dq_oe));

  a_r3_drive_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  a_r2_row_before_write_cas: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cas_n) && !mem_we_n) |-> !$past(mem_ras_n));

  a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && !mem_cas_n) |-> $past(!mem_cas_n));

  a_r4_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(mem_ras_n) && $past(mem_cas_n)) || ($fell(mem_cas_n) && $past(mem_ras_n)))
      |-> hi_cnt >= 8'(T_PRE));

  a_r4_ready_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ras_n && mem_cas_n));

  a_r3_rsp_in_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_ras_n && mem_cas_n && !req_ready));
endmodule

bind dram_seq_ctrl dram_seq_ctrl_chk #(.T_PRE(T_PRE), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out)
);

// File: tb/test_dram_seq_ctrl.sv
`timescale 1ns/1ps
module test_dram_seq_ctrl;
  localparam int ROW_W = 4, COL_W = 5, DW = 64, ROWS = 4, REF_IV = 40;
  localparam int T_RCD = 2, T_CAS = 2, T_CL = 3, T_CSR = 1, T_RAS = 3, T_PRE = 2;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, refresh_mode = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, mem_dq_in = '0;
  logic req_ready, rsp_valid, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  dram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .ROWS(ROWS), .REF_INTERVAL(REF_IV),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CL(T_CL), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_PRE(T_PRE))
  i_dram_seq_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // DRAM stub and strobe monitor, all on the falling edge
  logic [DW-1:0] mem [int];
  logic [DW-1:0] model [int];
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [ROW_W-1:0] st_row;
  bit cas_first, cas_inside;
  logic [AW-1:0] ras_addr;
  int cbr_n = 0, ror_n = 0, ref_n = 0;
  int ror_rows [16];

  always @(negedge clk) begin
    if (prev_ras && !mem_ras_n) begin
      st_row     = mem_addr[ROW_W-1:0];
      ras_addr   = mem_addr;
      cas_first  = !mem_cas_n;
      cas_inside = !mem_cas_n;
    end
    if (!mem_ras_n && !mem_cas_n) cas_inside = 1'b1;
    if (prev_cas && !mem_cas_n && !mem_ras_n) begin
      if (!mem_we_n) mem[int'({st_row, mem_addr})] = mem_dq_out;
      else mem_dq_in = mem.exists(int'({st_row, mem_addr})) ? mem[int'({st_row, mem_addr})] : '0;
    end
    if (!prev_ras && mem_ras_n) begin
      if (cas_first) begin cbr_n++; ref_n++; end
      else if (!cas_inside) begin
        if (ror_n < 16) ror_rows[ror_n] = int'(ras_addr);
        ror_n++; ref_n++;
      end
    end
    prev_ras = mem_ras_n;
    prev_cas = mem_cas_n;
  end

  task automatic wait_refresh();
    int start = ref_n;
    while (ref_n == start) @(negedge clk);
  endtask

  // returns number of falling edges seen with ready low before acceptance
  task automatic accept(input bit wr, input logic [ROW_W+COL_W-1:0] a, input logic [63:0] d, output int waits);
    waits = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) begin waits++; @(negedge clk); end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // timed access after acceptance; at entry the first falling edge after acceptance
  task automatic access(input bit wr, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                        input logic [63:0] d, input string tag);
    int w; bit ok; logic [63:0] exp;
    accept(wr, {r, c}, d, w);
    ok = 1;
    for (int k = 0; k < T_RCD; k++) begin
      ok &= !mem_ras_n && mem_cas_n && mem_we_n && mem_addr == AW'(r);
      if (k < T_RCD - 1) @(negedge clk);
    end
    check(ok, {"R2 row phase ", tag}, {mem_ras_n, mem_cas_n, mem_we_n}, 3'b011);
    ok = 1;
    for (int k = 0; k < (wr ? T_CAS : T_CL); k++) begin
      @(negedge clk);
      ok &= !mem_ras_n && !mem_cas_n && mem_addr == AW'(c) && !rsp_valid;
      if (wr) ok &= !mem_we_n && mem_dq_oe && mem_dq_out == d;
      else    ok &= mem_we_n && !mem_dq_oe;
    end
    check(ok, wr ? {"R2 write column phase ", tag} : {"R3 read column phase ", tag},
          {mem_ras_n, mem_cas_n, mem_we_n}, {2'b00, !wr});
    @(negedge clk);
    if (!wr) begin
      exp = model.exists(int'({r, c})) ? model[int'({r, c})] : '0;
      check(rsp_valid && rsp_rdata == exp, {"R3 read data ", tag}, rsp_rdata, exp);
    end else begin
      model[int'({r, c})] = d;
      check(!rsp_valid, {"R2 no response on write ", tag}, rsp_valid, 0);
    end
    ok = 1;
    for (int k = 0; k < T_PRE; k++) begin
      if (k > 0) @(negedge clk);
      ok &= mem_ras_n && mem_cas_n && !req_ready;
      if (k > 0) ok &= !rsp_valid;
    end
    check(ok, {"R4 precharge ", tag}, {mem_ras_n, mem_cas_n, req_ready}, 3'b110);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe && !rsp_valid, "R1 in reset",
          {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ras_n && mem_cas_n && mem_we_n, "R1 after reset",
          {req_ready, mem_ras_n, mem_cas_n, mem_we_n}, 4'b1111);
  endtask

  task automatic t_write_read();
    wait_refresh();
    access(1'b1, 4'd5, 5'd9, 64'hDEAD_BEEF_0123_4567, "w1");
    access(1'b0, 4'd5, 5'd9, '0, "r1");
    wait_refresh();
    access(1'b1, 4'd12, 5'd31, 64'h8000_0000_0000_0001, "w2");
    access(1'b1, 4'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, "w3");
    access(1'b0, 4'd12, 5'd31, '0, "r2");
    wait_refresh();
    access(1'b0, 4'd0, 5'd0, '0, "r3");
    access(1'b0, 4'd3, 5'd3, '0, "r4 unwritten");
  endtask

  task automatic t_cbr();
    int c0 = cbr_n, r0 = ror_n, cas_low = 0;
    refresh_mode = 1'b0;
    while (!(!mem_cas_n && mem_ras_n)) @(negedge clk);
    while (mem_ras_n) begin cas_low++; @(negedge clk); end
    check(cas_low == T_CSR, "R5 CAS lead cycles", cas_low, T_CSR);
    wait_refresh();
    check(cbr_n == c0 + 1 && ror_n == r0, "R5 CBR refresh seen", cbr_n - c0, 1);
  endtask

  task automatic t_ror();
    int r0 = ror_n, ras_low = 0; bit cas_ok = 1;
    refresh_mode = 1'b1;
    while (ror_n < r0 + 6) begin
      @(negedge clk);
      if (!mem_ras_n && ror_n == r0) begin ras_low++; cas_ok &= mem_cas_n; end
    end
    check(ras_low == T_RAS && cas_ok, "R6 RAS-only pulse", ras_low, T_RAS);
    for (int k = 0; k < 6; k++)
      check(ror_rows[r0 + k] == (r0 + k) % ROWS, "R9 refresh row sequence", ror_rows[r0 + k], (r0 + k) % ROWS);
    refresh_mode = 1'b0;
  endtask

  task automatic t_hold();
    int w;
    refresh_mode = 1'b0;
    while (!(!mem_cas_n && mem_ras_n)) @(negedge clk);
    accept(1'b0, {4'd5, 5'd9}, '0, w);
    check(w == T_CSR + T_RAS + T_PRE, "R7 ready low through refresh", w, T_CSR + T_RAS + T_PRE);
    while (!rsp_valid) @(negedge clk);
    check(rsp_rdata == 64'hDEAD_BEEF_0123_4567, "R7 held read data", rsp_rdata, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
  endtask

  task automatic t_stream();
    int r0 = ref_n;
    for (int i = 0; i < 12; i++)
      access(1'b0, 4'd12, 5'd31, '0, "R8 stream");
    check(ref_n > r0, "R8 refresh ticks inside stream", ref_n - r0, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_read();
    t_cbr();
    t_ror();
    t_hold();
    t_stream();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule